// File: doc/BRIEF.md
# Multi-Mode Clock Domain Synchronizer

This block moves a single-bit signal from a source clock domain into an unrelated destination clock domain. A build-time mode parameter picks one of three transfer styles. Pulse mode carries one-cycle events by flipping a source-side toggle flop and detecting each toggle edge after synchronization. Level mode carries slow, quasi-static signals such as reset requests through a plain flop chain. Acknowledged mode carries events over a four-phase request/acknowledge handshake and tells the source when it may send again.

The number of synchronizer stages is a parameter; values below 2 are raised to 2. For reset distribution, level mode with five stages is the intended setting. Every synchronizer stage is a separate resettable flop that clears to zero, so releasing reset never produces an output event.

Top module: `cdc_sync_multi`

## Requirements
- R1: In pulse mode, each source clock edge that samples `src_d_i` high yields exactly one destination pulse, one destination cycle wide, when consecutive source pulses are more than two destination periods apart.
- R2: In level mode, `dst_o` follows every change of `src_d_i` after the synchronizer delay, with no other change.
- R3: With N the effective stage count, the destination event appears N to N+1 destination edges after the source event. The source event is the source edge that samples the input (pulse and acknowledged modes) or the input change itself (level mode).
- R4: In acknowledged mode, a pulse sampled while `src_busy_o` is low is accepted: `src_busy_o` is high after that source edge and stays high until the acknowledge has returned and dropped. Each accepted pulse yields one destination pulse.
- R5: In acknowledged mode, a pulse sampled while `src_busy_o` is high is dropped and yields no destination pulse. `src_overrun_o` is high from the next source edge and stays high until source reset.
- R6: A stage count below 2 behaves as 2, so a level-mode instance built with 1 stage has a latency of 2 destination edges.
- R7: All synchronizer flops reset to zero. All outputs are low during reset and stay low after release while the input is held low.
- R8: In pulse and level modes, `src_busy_o` and `src_overrun_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source clock |
| src_rst_ni | input | 1 | Source-domain asynchronous reset, active low |
| src_d_i | input | 1 | Event (pulse/ack modes) or level to transfer |
| dst_clk_i | input | 1 | Destination clock |
| dst_rst_ni | input | 1 | Destination-domain asynchronous reset, active low |
| dst_o | output | 1 | Synchronized pulse or level |
| src_busy_o | output | 1 | Handshake in flight (acknowledged mode only) |
| src_overrun_o | output | 1 | Sticky flag: a pulse was dropped while busy |

## Verification
The clocks run at 10 ns and 14 ns, and their edges never coincide, so every latency measurement counts whole destination edges. Pulse mode is driven with closely spaced pulses, four source cycles apart, to show that the toggle scheme keeps adjacent events separate. It is also driven with widely spaced pulses to confirm the latency window. Level mode is driven with isolated toggles on a five-stage instance and on a one-stage instance; the one-stage instance shows the depth clamp. Acknowledged mode receives one accepted pulse, then a pulse during the handshake that must be dropped and flagged, then a further pulse after busy clears, which shows that the flag is sticky and that the source is accepted again.

// File: rtl/cdc_sync_pkg.sv
package cdc_sync_pkg;
  typedef enum logic [1:0] {
    XFER_PULSE = 2'd0,
    XFER_LEVEL = 2'd1,
    XFER_ACK   = 2'd2
  } xfer_mode_e;

  function automatic int unsigned clamp_depth(input int unsigned n);
    return (n < 2) ? 2 : n;
  endfunction
endpackage

// File: rtl/cdc_sync_chain.sv
// Plain synchronizer: DEPTH resettable flops, cleared to zero.
module cdc_sync_chain #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[DEPTH-2:0], d_i};
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/cdc_pulse_xfer.sv
// Toggle-based event transfer.
module cdc_pulse_xfer #(
  parameter int unsigned DEPTH = 2
) (
  input  logic src_clk_i,
  input  logic src_rst_ni,
  input  logic src_d_i,
  input  logic dst_clk_i,
  input  logic dst_rst_ni,
  output logic dst_o
);
  logic tog_q, tog_sync, tog_last_q;

  always_ff @(posedge src_clk_i or negedge src_rst_ni) begin
    if (!src_rst_ni)  tog_q <= 1'b0;
    else if (src_d_i) tog_q <= ~tog_q;
  end

  cdc_sync_chain #(.DEPTH(DEPTH)) u_tog_sync (
    .clk_i (dst_clk_i),
    .rst_ni(dst_rst_ni),
    .d_i   (tog_q),
    .q_o   (tog_sync)
  );

  always_ff @(posedge dst_clk_i or negedge dst_rst_ni) begin
    if (!dst_rst_ni) tog_last_q <= 1'b0;
    else             tog_last_q <= tog_sync;
  end

  assign dst_o = tog_sync ^ tog_last_q;
endmodule

// File: rtl/cdc_ack_xfer.sv
// Four-phase request/acknowledge event transfer.
module cdc_ack_xfer #(
  parameter int unsigned DEPTH = 2
) (
  input  logic src_clk_i,
  input  logic src_rst_ni,
  input  logic src_d_i,
  input  logic dst_clk_i,
  input  logic dst_rst_ni,
  output logic dst_o,
  output logic src_busy_o,
  output logic src_overrun_o
);
  logic req_q, ovr_q, ack_sync;
  logic req_sync, req_last_q;

  assign src_busy_o    = req_q | ack_sync;
  assign src_overrun_o = ovr_q;

  always_ff @(posedge src_clk_i or negedge src_rst_ni) begin
    if (!src_rst_ni) begin
      req_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (ack_sync)                     req_q <= 1'b0;
      else if (src_d_i && !src_busy_o)  req_q <= 1'b1;
      if (src_d_i && src_busy_o)        ovr_q <= 1'b1;
    end
  end

  cdc_sync_chain #(.DEPTH(DEPTH)) u_req_sync (
    .clk_i (dst_clk_i),
    .rst_ni(dst_rst_ni),
    .d_i   (req_q),
    .q_o   (req_sync)
  );

  always_ff @(posedge dst_clk_i or negedge dst_rst_ni) begin
    if (!dst_rst_ni) req_last_q <= 1'b0;
    else             req_last_q <= req_sync;
  end

  assign dst_o = req_sync & ~req_last_q;

  // acknowledge is the synchronized request level, returned to source
  cdc_sync_chain #(.DEPTH(DEPTH)) u_ack_sync (
    .clk_i (src_clk_i),
    .rst_ni(src_rst_ni),
    .d_i   (req_sync),
    .q_o   (ack_sync)
  );
endmodule

// File: rtl/cdc_sync_multi.sv
module cdc_sync_multi #(
  parameter cdc_sync_pkg::xfer_mode_e MODE = cdc_sync_pkg::XFER_PULSE,
  parameter int unsigned STAGES = 2
) (
  input  logic src_clk_i,
  input  logic src_rst_ni,
  input  logic src_d_i,
  input  logic dst_clk_i,
  input  logic dst_rst_ni,
  output logic dst_o,
  output logic src_busy_o,
  output logic src_overrun_o
);
  localparam int unsigned DEPTH = cdc_sync_pkg::clamp_depth(STAGES);

  if (MODE == cdc_sync_pkg::XFER_PULSE) begin : g_pulse
    cdc_pulse_xfer #(.DEPTH(DEPTH)) u_xfer (
      .src_clk_i (src_clk_i),
      .src_rst_ni(src_rst_ni),
      .src_d_i   (src_d_i),
      .dst_clk_i (dst_clk_i),
      .dst_rst_ni(dst_rst_ni),
      .dst_o     (dst_o)
    );
    assign src_busy_o    = 1'b0;
    assign src_overrun_o = 1'b0;
  end else if (MODE == cdc_sync_pkg::XFER_LEVEL) begin : g_level
    logic unused_src;
    assign unused_src = src_clk_i ^ src_rst_ni;
    cdc_sync_chain #(.DEPTH(DEPTH)) u_xfer (
      .clk_i (dst_clk_i),
      .rst_ni(dst_rst_ni),
      .d_i   (src_d_i),
      .q_o   (dst_o)
    );
    assign src_busy_o    = 1'b0;
    assign src_overrun_o = 1'b0;
  end else begin : g_ack
    cdc_ack_xfer #(.DEPTH(DEPTH)) u_xfer (
      .src_clk_i    (src_clk_i),
      .src_rst_ni   (src_rst_ni),
      .src_d_i      (src_d_i),
      .dst_clk_i    (dst_clk_i),
      .dst_rst_ni   (dst_rst_ni),
      .dst_o        (dst_o),
      .src_busy_o   (src_busy_o),
      .src_overrun_o(src_overrun_o)
    );
  end
endmodule

// File: rtl/cdc_sync_multi_chk.sv
module cdc_sync_multi_chk #(
  parameter cdc_sync_pkg::xfer_mode_e MODE = cdc_sync_pkg::XFER_PULSE
) (
  input logic src_clk_i,
  input logic src_rst_ni,
  input logic src_d_i,
  input logic dst_clk_i,
  input logic dst_rst_ni,
  input logic dst_o,
  input logic src_busy_o,
  input logic src_overrun_o
);
  localparam bit IS_ACK   = (MODE == cdc_sync_pkg::XFER_ACK);
  localparam bit IS_EVENT = (MODE != cdc_sync_pkg::XFER_LEVEL);

  a_r1_pulse_single_cycle: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    (IS_EVENT && dst_o) |=> !dst_o);

  a_r4_busy_on_accept: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    (IS_ACK && src_d_i && !src_busy_o) |=> src_busy_o);

  a_r5_overrun_on_drop: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    (IS_ACK && src_d_i && src_busy_o) |=> src_overrun_o);

  a_r5_overrun_sticky: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    src_overrun_o |=> src_overrun_o);
endmodule

bind cdc_sync_multi cdc_sync_multi_chk #(.MODE(MODE)) u_chk (
  .src_clk_i    (src_clk_i),
  .src_rst_ni   (src_rst_ni),
  .src_d_i      (src_d_i),
  .dst_clk_i    (dst_clk_i),
  .dst_rst_ni   (dst_rst_ni),
  .dst_o        (dst_o),
  .src_busy_o   (src_busy_o),
  .src_overrun_o(src_overrun_o)
);

// File: tb/cdc_sync_multi_tb_top.sv
module cdc_sync_multi_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DST_PERIOD = 14;

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
  logic ack_d = 1'b0, pls_d = 1'b0, lvl_d = 1'b0;
  logic ack_o, ack_busy, ack_ovr;
  logic pls_o, pls_busy, pls_ovr;
  logic lv5_o, lv5_busy, lv5_ovr;
  logic lv1_o, lv1_busy, lv1_ovr;

  int n_chk = 0, n_fail = 0, dst_cyc = 0;
  bit done = 1'b0;
  int q_ack[$], q_pls[$], q_lv5[$], q_lv1[$];
  logic lv5_prev = 1'b0, lv1_prev = 1'b0;

  // src posedges at 5+10k, dst posedges at 2+14m: never coincident
  always #(CLK_PERIOD/2) src_clk = ~src_clk;
  initial begin
    #2 dst_clk = 1'b1;
    forever #(DST_PERIOD/2) dst_clk = ~dst_clk;
  end
  always @(posedge dst_clk) dst_cyc++;

  cdc_sync_multi #(.MODE(cdc_sync_pkg::XFER_ACK), .STAGES(3)) dut_i (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n), .src_d_i(ack_d),
    .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n), .dst_o(ack_o),
    .src_busy_o(ack_busy), .src_overrun_o(ack_ovr));
  cdc_sync_multi #(.MODE(cdc_sync_pkg::XFER_PULSE), .STAGES(3)) dut_pulse (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n), .src_d_i(pls_d),
    .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n), .dst_o(pls_o),
    .src_busy_o(pls_busy), .src_overrun_o(pls_ovr));
  cdc_sync_multi #(.MODE(cdc_sync_pkg::XFER_LEVEL), .STAGES(5)) dut_lvl5 (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n), .src_d_i(lvl_d),
    .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n), .dst_o(lv5_o),
    .src_busy_o(lv5_busy), .src_overrun_o(lv5_ovr));
  cdc_sync_multi #(.MODE(cdc_sync_pkg::XFER_LEVEL), .STAGES(1)) dut_lvl1 (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n), .src_d_i(lvl_d),
    .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n), .dst_o(lv1_o),
    .src_busy_o(lv1_busy), .src_overrun_o(lv1_ovr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit in_window(input int d, input int n);
    return (d >= n) && (d <= n + 1);
  endfunction

  // monitors: pop one expected source event per observed destination event
  always @(posedge dst_clk) begin
    #1;
    if (pls_o) begin
      if (q_pls.size() == 0) chk(1'b0, "R1 unexpected pulse", 1, 0);
      else begin
        automatic int d = dst_cyc - q_pls.pop_front();
        chk(in_window(d, 3), "R1/R3 pulse latency", d, 3);
      end
    end
    if (ack_o) begin
      if (q_ack.size() == 0) chk(1'b0, "R5 unexpected ack-mode pulse", 1, 0);
      else begin
        automatic int d = dst_cyc - q_ack.pop_front();
        chk(in_window(d, 3), "R4/R3 ack-mode latency", d, 3);
      end
    end
    if (lv5_o != lv5_prev) begin
      lv5_prev = lv5_o;
      if (q_lv5.size() == 0) chk(1'b0, "R2 unexpected level change", 1, 0);
      else begin
        automatic int d = dst_cyc - q_lv5.pop_front();
        chk(in_window(d, 5), "R2/R3 level latency", d, 5);
      end
    end
    if (lv1_o != lv1_prev) begin
      lv1_prev = lv1_o;
      if (q_lv1.size() == 0) chk(1'b0, "R6 unexpected level change", 1, 0);
      else begin
        automatic int d = dst_cyc - q_lv1.pop_front();
        chk(in_window(d, 2), "R6 clamped depth latency", d, 2);
      end
    end
  end

  task automatic send_pls();
    @(negedge src_clk); #1 pls_d = 1'b1;
    @(posedge src_clk); q_pls.push_back(dst_cyc);
    @(negedge src_clk); #1 pls_d = 1'b0;
  endtask

  task automatic send_ack(input bit accept);
    @(negedge src_clk); #1 ack_d = 1'b1;
    @(posedge src_clk); if (accept) q_ack.push_back(dst_cyc);
    @(negedge src_clk); #1 ack_d = 1'b0;
  endtask

  task automatic flip_lvl();
    @(negedge src_clk); #1 lvl_d = ~lvl_d;
    q_lv5.push_back(dst_cyc);
    q_lv1.push_back(dst_cyc);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && ack_busy; i++) @(negedge src_clk);
    #1;
  endtask

  initial begin
    repeat (4) @(negedge src_clk);
    #1;
    chk(ack_o == 0 && pls_o == 0 && lv5_o == 0 && lv1_o == 0, "R7 outputs in reset",
        int'(ack_o | pls_o | lv5_o | lv1_o), 0);
    chk(ack_busy == 0 && ack_ovr == 0, "R7 flags in reset", int'(ack_busy | ack_ovr), 0);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    repeat (12) @(negedge src_clk);
    #1;
    chk(ack_o == 0 && pls_o == 0 && lv5_o == 0 && lv1_o == 0, "R7 quiet after release",
        int'(ack_o | pls_o | lv5_o | lv1_o), 0);
    chk(ack_busy == 0, "R7 busy low after release", int'(ack_busy), 0);

    // pulse mode: close spacing then wide spacing
    for (int i = 0; i < 4; i++) begin send_pls(); repeat (2) @(negedge src_clk); end
    for (int i = 0; i < 3; i++) begin send_pls(); repeat (9) @(negedge src_clk); end

    // level mode
    for (int i = 0; i < 3; i++) begin flip_lvl(); repeat (12) @(negedge src_clk); end

    // acknowledged mode
    send_ack(1'b1);
    chk(ack_busy == 1, "R4 busy after accept", int'(ack_busy), 1);
    chk(ack_ovr == 0, "R5 no overrun yet", int'(ack_ovr), 0);
    send_ack(1'b0);
    chk(ack_ovr == 1, "R5 overrun on dropped pulse", int'(ack_ovr), 1);
    chk(ack_busy == 1, "R4 busy held during handshake", int'(ack_busy), 1);
    wait_idle();
    chk(ack_busy == 0, "R4 busy clears after handshake", int'(ack_busy), 0);
    send_ack(1'b1);
    chk(ack_busy == 1, "R4 accepted again", int'(ack_busy), 1);
    chk(ack_ovr == 1, "R5 overrun sticky", int'(ack_ovr), 1);
    wait_idle();

    repeat (30) @(negedge src_clk);
    #1;
    chk(q_pls.size() == 0, "R1 all pulses delivered", q_pls.size(), 0);
    chk(q_ack.size() == 0, "R4 accepted pulse delivered", q_ack.size(), 0);
    chk(q_lv5.size() == 0, "R2 all level changes seen", q_lv5.size(), 0);
    chk(q_lv1.size() == 0, "R6 all level changes seen", q_lv1.size(), 0);
    chk(lv5_o == lvl_d && lv1_o == lvl_d, "R2 final level", int'(lv5_o), int'(lvl_d));
    chk((pls_busy | pls_ovr | lv5_busy | lv5_ovr | lv1_busy | lv1_ovr) == 0,
        "R8 flags low outside ack mode",
        int'(pls_busy | pls_ovr | lv5_busy | lv5_ovr | lv1_busy | lv1_ovr), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule